// File: doc/BRIEF.md
# Sequential Binary to Decimal Digit Converter

This block converts an unsigned binary word into packed decimal digits, four bits per digit, by the shift-and-add-3 method. One correction-and-shift step is performed per clock over a single register that chains the decimal columns above the remaining binary bits. With the defaults, an 8-bit value becomes three digits (hundreds, tens, ones) after eight steps.

A conversion starts when `start_i` is sampled high while `ready_o` is high. `ready_o` then stays low until the result is written. On the clock edge that performs the last shift, the result register `bcd_o` is loaded and `done_o` goes high for one cycle. Between results, `bcd_o` keeps the last value it was given. The reset is active-low and asynchronous.

Top module: `bin2bcd_seq`

## Requirements
- R1: Before every shift, each 4-bit decimal column holding 5 or more is increased by 3. As a result, no digit in the chain ever exceeds 9 during a conversion.
- R2: Each shift moves the chain left by one bit. The binary MSB enters the ones LSB, the ones MSB enters the tens LSB, and the tens MSB enters the hundreds LSB.
- R3: The conversion performs exactly BIN_W shifts. `done_o` is high in the cycle that follows the BIN_W-th rising edge after the edge that sampled the start.
- R4: The result is packed with hundreds in `bcd_o[11:8]`, tens in `bcd_o[7:4]` and ones in `bcd_o[3:0]`. For example, 162 gives 12'h162 and 243 gives 12'h243.
- R5: The decimal columns are cleared when a conversion begins, so a conversion never depends on the previous one.
- R6: A start pulse that arrives while a conversion is running is ignored. This includes a pulse in the cycle of the final shift: the running result is unchanged and no further conversion follows.
- R7: `done_o` is a one-cycle pulse.
- R8: `ready_o` is low from the edge that accepts a start until the edge that produces the result, and high at all other times.
- R9: `bcd_o` changes only on the edge that raises `done_o`.
- R10: After reset, `bcd_o` is 0, `done_o` is 0 and `ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only while ready |
| bin_i | input | BIN_W | Binary value sampled with the start |
| ready_o | output | 1 | High when idle and able to accept a start |
| bcd_o | output | 4*DIGITS | Last converted result, one digit per nibble |
| done_o | output | 1 | One-cycle pulse when bcd_o is updated |

## Verification
Two events can fall in the same cycle: a new start request and the final shift that writes the result. The bench raises `start_i` with a different operand in the cycle before the last shift edge, and again in the middle of a conversion. It then requires that `bcd_o` holds the value expected for the original operand, that `done_o` pulses exactly once, and that `ready_o` stays high with no further pulse for many cycles afterwards. Expected digits come from division by 10 and 100 in the bench, applied to random and corner-case inputs.

// File: rtl/bin2bcd_pkg.sv
package bin2bcd_pkg;
  localparam int unsigned NIBBLE_W = 4;

  // add-3 correction of one decimal column
  function automatic logic [NIBBLE_W-1:0] dd_fix(input logic [NIBBLE_W-1:0] d);
    return (d >= 4'd5) ? d + 4'd3 : d;
  endfunction
endpackage

// File: rtl/bin2bcd_col_adj.sv
module bin2bcd_col_adj
  import bin2bcd_pkg::*;
#(
  parameter int unsigned DIGITS = 3
) (
  input  logic [NIBBLE_W*DIGITS-1:0] col_i,
  output logic [NIBBLE_W*DIGITS-1:0] col_o
);
  for (genvar g = 0; g < DIGITS; g++) begin : g_col
    assign col_o[g*NIBBLE_W +: NIBBLE_W] = dd_fix(col_i[g*NIBBLE_W +: NIBBLE_W]);
  end
endmodule

// File: rtl/bin2bcd_ctrl.sv
module bin2bcd_ctrl #(
  parameter int unsigned STEPS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic shift_o,
  output logic last_o,
  output logic ready_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEPS - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign load_o  = start_i & ~busy_q;
  assign shift_o = busy_q;
  assign last_o  = busy_q & (cnt_q == LAST_CNT);
  assign ready_o = ~busy_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (last_o) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_ignores_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

  assert_last_returns_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (ready_o && done_o));

  assert_ready_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);
endmodule

// File: rtl/bin2bcd_seq.sv
module bin2bcd_seq
  import bin2bcd_pkg::*;
#(
  parameter int unsigned BIN_W  = 8,
  parameter int unsigned DIGITS = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [BIN_W-1:0]           bin_i,
  output logic                       ready_o,
  output logic [NIBBLE_W*DIGITS-1:0] bcd_o,
  output logic                       done_o
);
  localparam int unsigned DIG_W   = NIBBLE_W * DIGITS;
  localparam int unsigned CHAIN_W = DIG_W + BIN_W;

  logic               load, shift, last;
  logic [CHAIN_W-1:0] chain_q;
  logic [DIG_W-1:0]   adj_cols;
  logic [CHAIN_W-1:0] pre_shift;
  logic [CHAIN_W-1:0] chain_next;
  logic [DIG_W-1:0]   bcd_q;

  bin2bcd_ctrl #(.STEPS(BIN_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .shift_o (shift),
    .last_o  (last),
    .ready_o (ready_o),
    .done_o  (done_o)
  );

  bin2bcd_col_adj #(.DIGITS(DIGITS)) u_adj (
    .col_i (chain_q[CHAIN_W-1:BIN_W]),
    .col_o (adj_cols)
  );

  // correct columns, then shift the whole chain one bit left
  assign pre_shift  = {adj_cols, chain_q[BIN_W-1:0]};
  assign chain_next = pre_shift << 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      bcd_q   <= '0;
    end else begin
      if (load)       chain_q <= {{DIG_W{1'b0}}, bin_i};
      else if (shift) chain_q <= chain_next;
      if (last)       bcd_q   <= chain_next[CHAIN_W-1:BIN_W];
    end
  end

  assign bcd_o = bcd_q;

  for (genvar g = 0; g < DIGITS; g++) begin : g_chk
    assert_digit_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ready_o |-> (chain_q[BIN_W + g*NIBBLE_W +: NIBBLE_W] <= 4'd9));
    assert_result_digit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (bcd_o[g*NIBBLE_W +: NIBBLE_W] <= 4'd9));
  end

  assert_cols_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (chain_q[CHAIN_W-1:BIN_W] == '0));

  assert_result_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(bcd_o));
endmodule

// File: tb/bin2bcd_seq_tb.sv
module bin2bcd_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BIN_W = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  bin_i = '0;
  logic        ready_o;
  logic [11:0] bcd_o;
  logic        done_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bin2bcd_seq #(.BIN_W(BIN_W), .DIGITS(3)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .bin_i(bin_i),
    .ready_o(ready_o), .bcd_o(bcd_o), .done_o(done_o)
  );

  function automatic logic [11:0] exp_bcd(input logic [7:0] v);
    int n = int'(v);
    return {4'(n / 100), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // mid: negedge index (1..BIN_W) at which a competing start is raised, 0 = none
  task automatic convert(input logic [7:0] v, input int mid);
    logic [11:0] prev;
    prev = bcd_o;
    @(negedge clk);
    start_i = 1'b1;
    bin_i = v;
    @(negedge clk);
    start_i = 1'b0;
    bin_i = ~v;
    check(!ready_o, "R8 ready low after start", 32'(ready_o), 0);
    for (int i = 1; i < BIN_W; i++) begin
      if (i == mid) begin start_i = 1'b1; bin_i = v ^ 8'h5A; end
      @(negedge clk);
      start_i = 1'b0;
      check(!done_o, "R3 no early done", 32'(done_o), 0);
      check(bcd_o == prev, "R9 result held while busy", 32'(bcd_o), 32'(prev));
      check(!ready_o, "R8 busy during conversion", 32'(ready_o), 0);
    end
    if (mid == BIN_W) begin start_i = 1'b1; bin_i = 8'd37; end
    @(negedge clk);
    start_i = 1'b0;
    check(done_o, "R3 done after BIN_W shifts", 32'(done_o), 1);
    check(bcd_o == exp_bcd(v), "R4 R2 R1 digits", 32'(bcd_o), 32'(exp_bcd(v)));
    check(ready_o, "R8 ready with done", 32'(ready_o), 1);
    @(negedge clk);
    check(!done_o, "R7 done single cycle", 32'(done_o), 0);
    if (mid != 0) begin
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        check(!done_o && ready_o, "R6 ignored start caused no conversion", 32'({done_o, ready_o}), 1);
        check(bcd_o == exp_bcd(v), "R6 result unaffected", 32'(bcd_o), 32'(exp_bcd(v)));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(bcd_o == 12'h000, "R10 reset result", 32'(bcd_o), 0);
    check(!done_o, "R10 reset done", 32'(done_o), 0);
    check(ready_o, "R10 reset ready", 32'(ready_o), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    check(ready_o && !done_o, "R10 idle after reset", 32'({ready_o, done_o}), 2);

    convert(8'd162, 0);                           // R4
    check(bcd_o == 12'h162, "R4 162", 32'(bcd_o), 32'h162);
    convert(8'd243, 0);                           // R4
    check(bcd_o == 12'h243, "R4 243", 32'(bcd_o), 32'h243);
    convert(8'd255, 0);                           // R2 carry into hundreds
    convert(8'd0, 0);                             // R5 columns cleared after 255
    check(bcd_o == 12'h000, "R5 zero after 255", 32'(bcd_o), 0);
    convert(8'd5, 0);                             // R1 threshold
    convert(8'd4, 0);
    convert(8'd99, 0);
    convert(8'd100, 0);                           // R2 tens to hundreds
    convert(8'd128, 0);
    convert(8'd200, 4);                           // R6 mid-conversion start
    convert(8'd59, BIN_W);                        // R6 start in final shift cycle

    for (int k = 0; k < 40; k++) begin
      v = 8'($urandom);
      convert(v, (k % 5 == 0) ? 1 + (k % BIN_W) : 0);
    end

    // reset in the middle of a conversion clears everything (R10)
    @(negedge clk); start_i = 1'b1; bin_i = 8'd77;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    check(bcd_o == 12'h000 && !done_o && ready_o, "R10 reset mid conversion",
          32'({bcd_o, done_o, ready_o}), 32'h0001);
    rst_ni = 1'b1;
    convert(8'd77, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule